// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is a register-driven SPI master for serial flash devices. Software loads an address register and a data register, then writes a command word. That write launches one transaction. The engine selects the flash, shifts out an opcode byte, up to three address bytes and up to fifteen zero dummy bytes, and then sends or receives up to four data bytes. Bytes received in a read land in the data register.

A keep-selected bit in the command word leaves chip select asserted when the command ends. The next command then continues the same flash transaction without repeating its opcode, so a long read or program is built from a chain of short commands. A status register shows a pending flag while a command runs, and a sticky error flag. The serial clock idles high, data is sampled on its rising edge (SPI mode 3), and its half period is set in system clocks by a timing register.

Top module: `sflash_seq`

## Requirements
- R1: A write to register select 0 (command) while idle starts a transaction, and status bit 0 (pending) reads 1 from the next cycle until the transaction ends. Command layout: opcode in bits 7:0, address length 9:8, dummy length 13:10, data length 16:14, direction 17 (1 = write), keep-selected 18, chip-select index 20:19. If no chip select is held, the command asserts its chip select and sends the opcode MSB first.
- R2: An address length of 1 to 3 sends that many low bytes of the address register (select 1), most significant byte first. A length of 0 skips the address phase.
- R3: A dummy length of 1 to 15 sends that many 0x00 bytes after the address. A length of 0 skips the dummy phase.
- R4: A write command sends its data bytes from the data register (select 2), bits 7:0 first, each byte MSB first. Data length values 5 to 7 behave as 4.
- R5: A read command places received byte k into data register bits 8k+7:8k. The data is valid when pending clears, and bytes beyond the data length keep their old values.
- R6: With keep-selected set, chip select stays low after the command ends. A following command sends no opcode byte and continues with its address, dummy and data phases.
- R7: A command with data length 0 and keep-selected clear produces no SCK edge and releases chip select.
- R8: A command write while pending sets status bit 1 (error), and the engine ignores that command. Writing a 1 to bit 1 of the status register (select 3) clears the error flag.
- R9: SCK idles high. MOSI changes only when SCK falls. MISO is sampled on the rising edge.
- R10: The timing register (select 4) bits 2:0 set the SCK low and high time in system clocks. A value of 0 acts as 1, and a value of 7 acts as 6.
- R11: At most one chip select is low at any time, and its index is the one given by the command that asserted it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Register read data (combinational) |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
A wrong phase sequence or byte counter shows on the captured MOSI byte stream within one byte time (16 times the half period plus a few cycles). It appears as a missing, repeated or misplaced opcode, address or dummy byte. A corrupt held-select state shows at the next command as an extra opcode byte or a released chip select. Read lane errors appear in the data register as soon as pending clears. A divider fault shows in the first SCK low pulse after the command write.

// File: rtl/sfs_pkg.sv
// Shared definitions for the serial flash command sequencer.
// Assumes the command layout fixed here; software and engine both rely on it.
package sfs_pkg;
    localparam int SEL_W      = 3;
    localparam int CMD_W      = 21;
    localparam int DIV_W      = 3;
    localparam int DIV_MAX    = 6;

    localparam logic [SEL_W-1:0] SEL_CMD  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ADDR = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DATA = 3'd2;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd3;
    localparam logic [SEL_W-1:0] SEL_TIME = 3'd4;

    // Command word, MSB first: cs[20:19] keep[18] wr[17] dlen[16:14] dum[13:10] alen[9:8] opc[7:0]
    typedef struct packed {
        logic [1:0] cs;
        logic       keep;
        logic       wr;
        logic [2:0] dlen;
        logic [3:0] dum;
        logic [1:0] alen;
        logic [7:0] opc;
    } cmd_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA, PH_END
    } phase_e;
endpackage

// File: rtl/sfs_byte_engine.sv
// Byte shifter for SPI mode 3. On start it drops SCK, presents bit 7 of the
// byte and runs eight clock periods of half_per system clocks per level.
// MISO is taken when SCK rises; done pulses with the received byte.
// Assumes half_per is already within 1..DIV_MAX and start only while idle.
module sfs_byte_engine #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       tx,
    input  logic [DIV_W-1:0] half_per,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             done,
    output logic [7:0]       rx
);
    logic             busy_q;
    logic             sck_q;
    logic [2:0]       bit_q;
    logic [DIV_W-1:0] cnt_q;
    logic [7:0]       txs_q;
    logic [7:0]       rxs_q;
    logic             done_q;

    // Shift sequencing: level timer, bit count, shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b1;
            bit_q  <= '0;
            cnt_q  <= '0;
            txs_q  <= '0;
            rxs_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    sck_q  <= 1'b0;
                    bit_q  <= '0;
                    cnt_q  <= '0;
                    txs_q  <= tx;
                end
            end else if (cnt_q == half_per - 1'b1) begin
                cnt_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rxs_q <= {rxs_q[6:0], miso};
                end else if (bit_q == 3'd7) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    sck_q <= 1'b0;
                    txs_q <= {txs_q[6:0], 1'b0};
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sck  = sck_q;
    assign mosi = txs_q[7];
    assign done = done_q;
    assign rx   = rxs_q;
endmodule

// File: rtl/sfs_ctrl.sv
// Phase sequencer. Accepts a decoded command, drives chip select and walks
// opcode, address, dummy and data phases, issuing one byte at a time to the
// byte engine. Assumes go arrives only while pending is low.
module sfs_ctrl
    import sfs_pkg::*;
#(
    parameter int NUM_CS     = 2,
    parameter int ADDR_W     = 24,
    parameter int DATA_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  cmd_t                  cmd,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [8*DATA_BYTES-1:0] wdata,
    input  logic                  eng_done,
    input  logic [7:0]            eng_rx,
    output logic                  eng_start,
    output logic [7:0]            eng_tx,
    output logic                  pending,
    output logic [NUM_CS-1:0]     cs_n,
    output logic                  cap_we,
    output logic [1:0]            cap_lane,
    output logic [7:0]            cap_byte
);
    phase_e     phase_q;
    cmd_t       cmd_q;
    logic [3:0] idx_q;
    logic       start_q;
    logic       held_q;
    logic [1:0] csel_q;
    logic       pend_q;

    function automatic logic [3:0] data_len(cmd_t c);
        return (int'(c.dlen) > DATA_BYTES) ? 4'(DATA_BYTES) : {1'b0, c.dlen};
    endfunction

    function automatic logic [3:0] phase_len(phase_e p, cmd_t c);
        case (p)
            PH_OPC:   return 4'd1;
            PH_ADDR:  return {2'b00, c.alen};
            PH_DUMMY: return c.dum;
            PH_DATA:  return data_len(c);
            default:  return 4'd0;
        endcase
    endfunction

    // First non-empty phase strictly after p (PH_IDLE means opcode skipped).
    function automatic phase_e next_phase(phase_e p, cmd_t c);
        if ((p == PH_IDLE || p == PH_OPC) && c.alen != 2'd0)
            return PH_ADDR;
        if ((p == PH_IDLE || p == PH_OPC || p == PH_ADDR) && c.dum != 4'd0)
            return PH_DUMMY;
        if (p != PH_DATA && data_len(c) != 4'd0)
            return PH_DATA;
        return PH_END;
    endfunction

    // Command acceptance, phase advance and chip-select hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cmd_q   <= '0;
            idx_q   <= '0;
            start_q <= 1'b0;
            held_q  <= 1'b0;
            csel_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (go) begin
                cmd_q  <= cmd;
                pend_q <= 1'b1;
                idx_q  <= '0;
                if (data_len(cmd) == 4'd0 && !cmd.keep) begin
                    phase_q <= PH_END;
                end else if (!held_q) begin
                    phase_q <= PH_OPC;
                    held_q  <= 1'b1;
                    csel_q  <= cmd.cs;
                    start_q <= 1'b1;
                end else begin
                    phase_q <= next_phase(PH_IDLE, cmd);
                    start_q <= (next_phase(PH_IDLE, cmd) != PH_END);
                end
            end else if (phase_q == PH_END) begin
                pend_q  <= 1'b0;
                held_q  <= cmd_q.keep;
                phase_q <= PH_IDLE;
            end else if (eng_done) begin
                if (idx_q + 1'b1 < phase_len(phase_q, cmd_q)) begin
                    idx_q   <= idx_q + 1'b1;
                    start_q <= 1'b1;
                end else begin
                    idx_q   <= '0;
                    phase_q <= next_phase(phase_q, cmd_q);
                    start_q <= (next_phase(phase_q, cmd_q) != PH_END);
                end
            end
        end
    end

    // Byte selection for the phase in progress.
    always_comb begin
        logic [ADDR_W-1:0]       ashift;
        logic [8*DATA_BYTES-1:0] dshift;
        ashift = addr >> (8 * (int'(cmd_q.alen) - 1 - int'(idx_q)));
        dshift = wdata >> (8 * int'(idx_q));
        case (phase_q)
            PH_OPC:  eng_tx = cmd_q.opc;
            PH_ADDR: eng_tx = ashift[7:0];
            PH_DATA: eng_tx = cmd_q.wr ? dshift[7:0] : 8'h00;
            default: eng_tx = 8'h00;
        endcase
    end

    // One active-low select per device; only the latched index may be low.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !(held_q && csel_q == 2'(i));
    end

    assign eng_start = start_q;
    assign pending   = pend_q;
    assign cap_we    = eng_done && phase_q == PH_DATA && !cmd_q.wr;
    assign cap_lane  = idx_q[1:0];
    assign cap_byte  = eng_rx;
endmodule

// File: rtl/sflash_seq.sv
// Serial flash command sequencer top. Holds the software registers
// (address, data, status, timing), rejects commands while busy and connects
// the phase sequencer to the mode-3 byte engine.
// Assumes NUM_CS is between 1 and 4 and a 32-bit data register.
module sflash_seq
    import sfs_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int ADDR_W = 24,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [REG_W-1:0]  rd_data,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);
    localparam int DATA_BYTES = REG_W / 8;

    logic [ADDR_W-1:0] addr_q;
    logic [REG_W-1:0]  data_q;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  div_eff;
    logic              err_q;
    logic              pending;
    logic              cmd_wr;
    logic              go;
    logic              eng_start, eng_done;
    logic [7:0]        eng_tx, eng_rx;
    logic              cap_we;
    logic [1:0]        cap_lane;
    logic [7:0]        cap_byte;

    assign cmd_wr = wr_en && wr_sel == SEL_CMD;
    assign go     = cmd_wr && !pending;

    // Clamp the half period to the supported range.
    assign div_eff = (div_q == '0) ? DIV_W'(1) :
                     (int'(div_q) > DIV_MAX) ? DIV_W'(DIV_MAX) : div_q;

    // Software-visible registers and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            div_q  <= DIV_W'(1);
        end else begin
            if (wr_en && wr_sel == SEL_ADDR) addr_q <= wr_data[ADDR_W-1:0];
            if (wr_en && wr_sel == SEL_TIME) div_q  <= wr_data[DIV_W-1:0];
            if (wr_en && wr_sel == SEL_DATA) data_q <= wr_data;
            if (cap_we) data_q[8*cap_lane +: 8] <= cap_byte;
        end
    end

    // Sticky error: set by a command written while busy, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (cmd_wr && pending)
            err_q <= 1'b1;
        else if (wr_en && wr_sel == SEL_STAT && wr_data[1])
            err_q <= 1'b0;
    end

    // Register read multiplexer.
    always_comb begin
        case (rd_sel)
            SEL_ADDR: rd_data = REG_W'(addr_q);
            SEL_DATA: rd_data = data_q;
            SEL_STAT: rd_data = REG_W'({err_q, pending});
            SEL_TIME: rd_data = REG_W'(div_q);
            default:  rd_data = '0;
        endcase
    end

    sfs_ctrl #(
        .NUM_CS     (NUM_CS),
        .ADDR_W     (ADDR_W),
        .DATA_BYTES (DATA_BYTES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .cmd       (cmd_t'(wr_data[CMD_W-1:0])),
        .addr      (addr_q),
        .wdata     (data_q),
        .eng_done  (eng_done),
        .eng_rx    (eng_rx),
        .eng_start (eng_start),
        .eng_tx    (eng_tx),
        .pending   (pending),
        .cs_n      (cs_n),
        .cap_we    (cap_we),
        .cap_lane  (cap_lane),
        .cap_byte  (cap_byte)
    );

    sfs_byte_engine #(
        .DIV_W (DIV_W)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .tx       (eng_tx),
        .half_per (div_eff),
        .miso     (miso),
        .sck      (sck),
        .mosi     (mosi),
        .done     (eng_done),
        .rx       (eng_rx)
    );
endmodule

// File: rtl/sflash_seq_chk.sv
// Protocol checker for the sequencer, bound to every sflash_seq instance.
// Observes the register write port, the serial pins and the status flags.
module sflash_seq_chk
    import sfs_pkg::*;
#(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [31:0]       wr_data,
    input logic              sck,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs_n,
    input logic              pending,
    input logic              err
);
    logic cmd_wr;
    assign cmd_wr = wr_en && wr_sel == SEL_CMD;

    AST_PEND_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !pending) |=> pending);                              // R1
    AST_ERR_ON_BUSY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && pending) |=> err);                                   // R8
    AST_RELEASE_NO_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !pending && wr_data[16:14] == 3'd0 && !wr_data[18])
        |=> sck ##1 (&cs_n && sck));                                    // R7
    AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> sck);                                              // R9
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));                         // R9
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);                                        // R11
endmodule

bind sflash_seq sflash_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .sck     (sck),
    .mosi    (mosi),
    .cs_n    (cs_n),
    .pending (pending),
    .err     (err_q)
);

// File: tb/sflash_seq_test.sv
// Directed bench with a behavioural flash model: captures MOSI bytes on SCK
// rising edges and drives MISO on falling edges from a fixed byte pattern.
module sflash_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        sck, mosi;
    logic        miso = 1'b0;
    logic [1:0]  cs_n;

    int n_checks = 0;
    int n_fail   = 0;

    sflash_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- flash model ----------------
    logic [7:0] cap [0:63];
    int         cap_n = 0;
    int         tot_bits = 0;
    int         sck_rises = 0;
    logic [7:0] shreg = '0;
    logic       all_hi;
    assign all_hi = &cs_n;

    function automatic logic [7:0] pat(int n);
        return 8'hC3 ^ 8'(n * 29);
    endfunction

    always @(posedge sck) begin
        sck_rises++;
        if (!all_hi) begin
            shreg = {shreg[6:0], mosi};
            tot_bits++;
            if (tot_bits % 8 == 0) begin
                if (cap_n < 64) cap[cap_n] = shreg;
                cap_n++;
            end
        end
    end

    always @(posedge all_hi) tot_bits = 0;

    always @(negedge sck) begin
        logic [7:0] b;
        if (!all_hi) begin
            b = pat(tot_bits / 8);
            miso = b[7 - (tot_bits % 8)];
        end
    end

    // ---------------- helpers ----------------
    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(logic [7:0] opc, int alen, int dum,
                                           int dlen, bit wr, bit keep, int cs);
        return {11'b0, 2'(cs), keep, wr, 3'(dlen), 4'(dum), 2'(alen), opc};
    endfunction

    task automatic reg_wr(logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic [2:0] sel, output logic [31:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            reg_rd(3'd3, s);
            if (!s[0]) return;
            @(negedge clk);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] s;
        reg_rd(3'd3, s);
        check("R1 reset status", s, 32'h0);
        check("R11 reset selects", 32'(cs_n), 32'h3);
        check("R9 reset sck high", 32'(sck), 32'h1);
    endtask

    task automatic t_write();
        logic [31:0] s;
        reg_wr(3'd4, 32'd2);
        reg_wr(3'd1, 32'h00123456);
        reg_wr(3'd2, 32'h44332211);
        cap_n = 0;
        reg_wr(3'd0, mk_cmd(8'h02, 3, 2, 4, 1, 0, 0));
        reg_rd(3'd3, s);
        check("R1 pending after command", 32'(s[0]), 32'h1);
        wait_idle();
        check("R1 byte count", 32'(cap_n), 32'd10);
        check("R1 opcode", 32'(cap[0]), 32'h02);
        check("R2 addr hi", 32'(cap[1]), 32'h12);
        check("R2 addr mid", 32'(cap[2]), 32'h34);
        check("R2 addr lo", 32'(cap[3]), 32'h56);
        check("R3 dummy 0", 32'(cap[4]), 32'h00);
        check("R3 dummy 1", 32'(cap[5]), 32'h00);
        check("R4 data0", 32'(cap[6]), 32'h11);
        check("R4 data3", 32'(cap[9]), 32'h44);
        check("R6 released", 32'(cs_n), 32'h3);
    endtask

    task automatic t_len_clamp();
        reg_wr(3'd2, 32'hA1B2C3D4);
        cap_n = 0;
        reg_wr(3'd0, mk_cmd(8'h32, 0, 0, 7, 1, 0, 0));
        wait_idle();
        check("R4 clamp count", 32'(cap_n), 32'd5);
        check("R4 clamp last", 32'(cap[4]), 32'hA1);
    endtask

    task automatic t_read();
        logic [31:0] d;
        cap_n = 0;
        reg_wr(3'd1, 32'h00ABCDEF);
        reg_wr(3'd0, mk_cmd(8'h03, 3, 0, 4, 0, 0, 0));
        wait_idle();
        reg_rd(3'd2, d);
        check("R5 read four", d, {pat(7), pat(6), pat(5), pat(4)});
        check("R2 read addr", 32'(cap[1]), 32'hAB);
        reg_wr(3'd2, 32'hDEADBEEF);
        reg_wr(3'd0, mk_cmd(8'h0B, 0, 0, 2, 0, 0, 0));
        wait_idle();
        reg_rd(3'd2, d);
        check("R5 read two lanes kept", d, {16'hDEAD, pat(2), pat(1)});
    endtask

    task automatic t_keep();
        cap_n = 0;
        reg_wr(3'd1, 32'h00000077);
        reg_wr(3'd2, 32'h0000005A);
        reg_wr(3'd0, mk_cmd(8'h0B, 1, 0, 1, 1, 1, 0));
        wait_idle();
        check("R6 held low", 32'(cs_n), 32'h2);
        reg_wr(3'd2, 32'h00008877);
        reg_wr(3'd0, mk_cmd(8'hFF, 0, 0, 2, 1, 0, 0));
        wait_idle();
        check("R6 chained count", 32'(cap_n), 32'd5);
        check("R6 no second opcode", 32'(cap[3]), 32'h77);
        check("R6 chained last", 32'(cap[4]), 32'h88);
        check("R6 released at end", 32'(cs_n), 32'h3);
    endtask

    task automatic t_release();
        int r0;
        cap_n = 0;
        reg_wr(3'd0, mk_cmd(8'h06, 0, 0, 0, 1, 1, 0));
        wait_idle();
        check("R7 opcode only", 32'(cap_n), 32'd1);
        check("R7 held", 32'(cs_n), 32'h2);
        r0 = sck_rises;
        reg_wr(3'd0, mk_cmd(8'h00, 0, 0, 0, 0, 0, 0));
        wait_idle();
        @(negedge clk);
        check("R7 no sck", 32'(sck_rises - r0), 32'd0);
        check("R7 released", 32'(cs_n), 32'h3);
    endtask

    task automatic t_error();
        logic [31:0] s;
        cap_n = 0;
        reg_wr(3'd0, mk_cmd(8'h9F, 0, 0, 4, 0, 0, 0));
        reg_wr(3'd0, mk_cmd(8'h55, 0, 0, 1, 1, 0, 0));
        reg_rd(3'd3, s);
        check("R8 error and pending", s, 32'h3);
        wait_idle();
        check("R8 ignored count", 32'(cap_n), 32'd5);
        check("R8 first opcode", 32'(cap[0]), 32'h9F);
        reg_rd(3'd3, s);
        check("R8 error sticky", s, 32'h2);
        reg_wr(3'd3, 32'h2);
        reg_rd(3'd3, s);
        check("R8 error cleared", s, 32'h0);
    endtask

    task automatic t_div(int val, int exp);
        int lo = 0;
        reg_wr(3'd4, 32'(val));
        reg_wr(3'd0, mk_cmd(8'h05, 0, 0, 1, 0, 0, 0));
        for (int i = 0; i < 50 && sck; i++) @(negedge clk);
        while (!sck && lo < 50) begin
            lo++;
            @(negedge clk);
        end
        check($sformatf("R10 low time div=%0d", val), 32'(lo), 32'(exp));
        wait_idle();
    endtask

    task automatic t_cs_sel();
        reg_wr(3'd4, 32'd1);
        reg_wr(3'd0, mk_cmd(8'h06, 0, 0, 0, 1, 1, 1));
        wait_idle();
        check("R11 select index 1", 32'(cs_n), 32'h1);
        reg_wr(3'd0, mk_cmd(8'h00, 0, 0, 0, 0, 0, 0));
        wait_idle();
        @(negedge clk);
        check("R11 index released", 32'(cs_n), 32'h3);
        check("R9 sck idle after", 32'(sck), 32'h1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_len_clamp();
        t_read();
        t_keep();
        t_release();
        t_error();
        t_div(0, 1);
        t_div(3, 3);
        t_div(7, 6);
        t_cs_sel();
        finish_run();
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule